// File: doc/BRIEF.md
# Overlap-Qualified Pulse Strobe with Deferred Timestamp

This block sits behind a leading-edge discriminator in a sampling channel. It decides whether each firing belongs to a lone pulse or to a pile-up of pulses. A firing counts as isolated when no other firing lands inside the summation window of length N clocks, either before it or after it. Each firing adds one to an occupancy counter. A copy of the firing, delayed by N clocks, subtracts one again. When the counter would reach two or more, every pulse then inside the window is tagged as overlapped.

The decision can only be made once the trailing part of the window has been seen, so the qualified strobe appears N clocks after the firing. The timestamp sampled at the moment of firing waits in a small queue. It leaves the queue when the delayed copy arrives, and it is presented only when the pulse was found isolated. The block also drives a plain pile-up flag for downstream readout-mode logic.

The result port is a one-cycle strobe with its data. It has no ready input and applies no back-pressure: the consumer must take every strobe in the cycle it is shown, because the pulse pipeline cannot pause.

Top module: `pileup_qualifier`

## Requirements
- R1: The occupancy count rises by one on each firing and falls by one when that firing's delayed copy arrives. It is unchanged when both happen in the same cycle. It never goes below zero and never exceeds the window depth.
- R2: Take a firing sampled at clock edge c with window depth N. If it is isolated, `clean_valid_o` is high for exactly one cycle, the one following edge c+N, and at no other time.
- R3: Whenever `clean_valid_o` is high, `clean_ts_o` equals the `ts_i` value sampled at that pulse's firing edge, and not the time of the strobe.
- R4: After edge k, `pileup_o` is high exactly when two or more firings were sampled at edges k-N+1 through k.
- R5: A firing with another firing fewer than N cycles before it, or fewer than N cycles after it, produces no `clean_valid_o` strobe.
- R6: Firings spaced exactly N cycles apart, or further, are each qualified as clean, including back-to-back chains of such firings.
- R7: `depth_i` sets N at run time. A value of 0 behaves as 1, and values above MAX_DEPTH behave as MAX_DEPTH. It is changed only while no firing is inside the window.
- R8: While `rst_n` is low, and in the first cycle after it rises, `clean_valid_o` and `pileup_o` are low and the window is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disc_i | input | 1 | Raw discriminator firing strobe |
| ts_i | input | TS_W | Free-running timestamp |
| depth_i | input | $clog2(MAX_DEPTH+1) | Window depth N in clocks |
| clean_valid_o | output | 1 | One-cycle strobe for an isolated pulse, N clocks late |
| clean_ts_o | output | TS_W | Firing timestamp of the qualified pulse |
| pileup_o | output | 1 | High while two or more firings share the window |

## Verification
The bench builds the block with MAX_DEPTH = 8 and TS_W = 12. This small size lets every depth from 1 to 8 be swept, along with the out-of-range settings 0 and 12. For each depth it runs a single firing, every pair spacing from 1 to N+1, a bursting run of firings, exact-N chains, and a chain whose last link comes one cycle early. The expected pile-up flag and strobes are worked out cycle by cycle from the firing times alone. Pulses closer than N apart on either side are flagged, and pulses exactly N apart are accepted.

// File: rtl/pq_pkg.sv
package pq_pkg;

  typedef enum logic [1:0] {
    OCC_HOLD = 2'd0,
    OCC_UP   = 2'd1,
    OCC_DOWN = 2'd2
  } occ_move_e;

  function automatic occ_move_e occ_move(input logic up, input logic down);
    if (up && !down) return OCC_UP;
    if (down && !up) return OCC_DOWN;
    return OCC_HOLD;
  endfunction

endpackage

// File: rtl/pq_delay_line.sv
module pq_delay_line #(
  parameter int MAX_DEPTH = 64,
  localparam int DEPTH_W = $clog2(MAX_DEPTH + 1),
  localparam int IDX_W = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe_i,
  input  logic [DEPTH_W-1:0] depth_i,
  output logic               delayed_o
);

  logic [MAX_DEPTH-1:0] taps;
  logic [IDX_W-1:0]     sel;

  for (genvar g = 0; g < MAX_DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) taps[g] <= 1'b0;
        else        taps[g] <= strobe_i;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) taps[g] <= 1'b0;
        else        taps[g] <= taps[g-1];
      end
    end
  end

  // clamp the programmed depth into 1..MAX_DEPTH (R7)
  always_comb begin
    if (depth_i == '0)                  sel = '0;
    else if (int'(depth_i) > MAX_DEPTH) sel = IDX_W'(MAX_DEPTH - 1);
    else                                sel = IDX_W'(int'(depth_i) - 1);
  end

  assign delayed_o = taps[sel];

endmodule

// File: rtl/pq_occupancy.sv
module pq_occupancy
  import pq_pkg::*;
#(
  parameter int MAX_DEPTH = 64,
  localparam int CNT_W = $clog2(MAX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_i,
  input  logic             down_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o <= '0;
    end else begin
      case (occ_move(up_i, down_i))
        OCC_UP:   cnt_o <= cnt_o + 1'b1;
        OCC_DOWN: cnt_o <= cnt_o - 1'b1;
        default:  cnt_o <= cnt_o;
      endcase
    end
  end

  assert_no_underflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (down_i && !up_i) |-> (cnt_o != '0));

  assert_count_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_o) <= MAX_DEPTH);

endmodule

// File: rtl/pq_ts_fifo.sv
module pq_ts_fifo #(
  parameter int DEPTH = 64,
  parameter int TS_W  = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [TS_W-1:0]  push_ts_i,
  input  logic             taint_all_i,
  input  logic             pop_i,
  output logic [TS_W-1:0]  head_ts_o,
  output logic             head_dirty_o,
  output logic [LVL_W-1:0] level_o
);

  logic [TS_W-1:0]  ts_mem [DEPTH];
  logic [DEPTH-1:0] dirty_q;
  logic [PTR_W-1:0] wp, rp;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      level_o <= '0;
      dirty_q <= '0;
    end else begin
      if (taint_all_i) dirty_q <= '1;
      if (push_i) begin
        ts_mem[wp]  <= push_ts_i;
        dirty_q[wp] <= taint_all_i;
        wp          <= bump(wp);
      end
      if (pop_i) rp <= bump(rp);
      case ({push_i, pop_i})
        2'b10:   level_o <= level_o + 1'b1;
        2'b01:   level_o <= level_o - 1'b1;
        default: level_o <= level_o;
      endcase
    end
  end

  assign head_ts_o    = ts_mem[rp];
  assign head_dirty_o = dirty_q[rp];

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |-> (level_o < LVL_W'(DEPTH)));

  assert_pop_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (level_o != '0));

endmodule

// File: rtl/pileup_qualifier.sv
module pileup_qualifier #(
  parameter int TS_W      = 32,
  parameter int MAX_DEPTH = 64,
  localparam int DEPTH_W = $clog2(MAX_DEPTH + 1),
  localparam int CNT_W   = $clog2(MAX_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               disc_i,
  input  logic [TS_W-1:0]    ts_i,
  input  logic [DEPTH_W-1:0] depth_i,
  output logic               clean_valid_o,
  output logic [TS_W-1:0]    clean_ts_o,
  output logic               pileup_o
);

  logic             expire;
  logic [CNT_W-1:0] occ_cnt;
  logic [CNT_W:0]   occ_next;
  logic             taint;
  logic [TS_W-1:0]  head_ts;
  logic             head_dirty;
  logic [CNT_W-1:0] fifo_level;

  pq_delay_line #(.MAX_DEPTH(MAX_DEPTH)) delay_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe_i  (disc_i),
    .depth_i   (depth_i),
    .delayed_o (expire)
  );

  pq_occupancy #(.MAX_DEPTH(MAX_DEPTH)) occ_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .up_i   (disc_i),
    .down_i (expire),
    .cnt_o  (occ_cnt)
  );

  // occupancy as it will stand after this edge; two or more taints the window
  always_comb begin
    occ_next = {1'b0, occ_cnt};
    if (disc_i && !expire)      occ_next = occ_next + 1'b1;
    else if (expire && !disc_i) occ_next = occ_next - 1'b1;
  end
  assign taint = (occ_next >= (CNT_W+1)'(2));

  pq_ts_fifo #(.DEPTH(MAX_DEPTH), .TS_W(TS_W)) fifo_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (disc_i),
    .push_ts_i    (ts_i),
    .taint_all_i  (taint),
    .pop_i        (expire),
    .head_ts_o    (head_ts),
    .head_dirty_o (head_dirty),
    .level_o      (fifo_level)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clean_valid_o <= 1'b0;
      clean_ts_o    <= '0;
    end else begin
      clean_valid_o <= expire && !head_dirty;
      if (expire) clean_ts_o <= head_ts;
    end
  end

  assign pileup_o = (occ_cnt >= CNT_W'(2));

  assert_level_tracks_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level == occ_cnt);

  assert_crowded_expiry_rejected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_cnt >= CNT_W'(2) && expire) |=> !clean_valid_o);

  assert_strobe_follows_expiry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clean_valid_o |-> $past(expire));

endmodule

// File: tb/pileup_qualifier_tb_top.sv
module pileup_qualifier_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TS_W       = 12;
  localparam int MAXD       = 8;
  localparam int DW         = $clog2(MAXD + 1);
  localparam int WIN        = 40;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            disc_i = 1'b0;
  logic [TS_W-1:0] ts_i = '0;
  logic [DW-1:0]   depth_i = DW'(1);
  logic            clean_valid_o;
  logic [TS_W-1:0] clean_ts_o;
  logic            pileup_o;

  int total = 0;
  int bad = 0;
  int base = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pileup_qualifier #(.TS_W(TS_W), .MAX_DEPTH(MAXD)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .disc_i        (disc_i),
    .ts_i          (ts_i),
    .depth_i       (depth_i),
    .clean_valid_o (clean_valid_o),
    .clean_ts_o    (clean_ts_o),
    .pileup_o      (pileup_o)
  );

  function automatic int eff_depth(input int d);
    if (d < 1) return 1;
    if (d > MAXD) return MAXD;
    return d;
  endfunction

  function automatic bit alone(input logic [63:0] p, input int i, input int n);
    for (int j = 0; j < 64; j++)
      if (j != i && p[j] && (j - i < n) && (i - j < n)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int in_window(input logic [63:0] p, input int k, input int n);
    int c = 0;
    for (int f = k - n + 1; f <= k; f++)
      if (f >= 0 && p[f]) c++;
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_scn(input int dval, input logic [63:0] pat, input string req);
    int n;
    bit exp_v;
    n = eff_depth(dval);
    @(negedge clk);
    depth_i = DW'(dval);
    for (int k = 0; k < WIN; k++) begin
      @(negedge clk);
      disc_i = pat[k];
      ts_i   = TS_W'(base + k);
      @(posedge clk);
      #(CLK_PERIOD/4);
      exp_v = (k - n >= 0) && pat[k-n] && alone(pat, k - n, n);
      check(clean_valid_o == exp_v, req, "clean_valid_o", int'(clean_valid_o), int'(exp_v));
      if (exp_v)
        check(clean_ts_o == TS_W'(base + k - n), "R3", "clean_ts_o",
              int'(clean_ts_o), int'(TS_W'(base + k - n)));
      // R1 R4: flag follows the firing count inside the window
      check(pileup_o == (in_window(pat, k, n) >= 2), "R4", "pileup_o",
            int'(pileup_o), int'(in_window(pat, k, n) >= 2));
    end
    @(negedge clk);
    disc_i = 1'b0;
    base += 53;
  endtask

  initial begin
    logic [63:0] p;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check(!clean_valid_o && !pileup_o, "R8", "outputs in reset", int'(clean_valid_o | pileup_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check(!clean_valid_o && !pileup_o, "R8", "outputs after reset", int'(clean_valid_o | pileup_o), 0);

    for (int d = 1; d <= MAXD; d++) begin
      run_scn(d, 64'h4, "R2");
      for (int g = 1; g <= d + 1; g++) begin
        p = '0; p[2] = 1'b1; p[2+g] = 1'b1;
        run_scn(d, p, (g < d) ? "R5" : "R6");
      end
      p = '0; p[2] = 1'b1; p[2+d] = 1'b1; p[2+2*d] = 1'b1;
      run_scn(d, p, "R6");
      p = '0; p[2] = 1'b1; p[2+d] = 1'b1; p[2+2*d-1] = 1'b1;
      run_scn(d, p, "R5");
      run_scn(d, 64'h3C, "R5");
    end
    // R7: out-of-range settings clamp
    run_scn(0, 64'h1_0014, "R7");
    run_scn(12, 64'h1_0204, "R7");
    run_scn(12, 64'h0_0404, "R7");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule